// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

An eight-input interrupt controller sits between peripheral request lines and a processor. Software talks to it over an 8-bit bus that has two ports, chosen by a single select bit: a command port and a data port. Writing a command byte with bit 4 set starts a short initialization handshake. The data port then takes between one and three further bytes, which set the vector base, the cascade wiring and the operating mode. After that, the data port reads and writes the per-input mask.

While the controller is operational, it resolves the requests with a fixed priority, in which input 0 ranks highest. It raises `intReq` when an unmasked request outranks everything already in service. When the processor pulses `intAck`, the winning request moves into the in-service set, and the next cycle presents the vector. That level stays in service until a nonspecific end-of-interrupt command arrives, unless automatic end of interrupt was selected. Reading the command port returns the in-service set, which lets software inspect nesting.

Top module: `prio_intc`

## Requirements
- R1: After reset the mask is 0xFF, the in-service set is empty, `intReq` is low, and the vector base is 0x00. Inputs are edge sensitive, the controller is in single mode (`singleMode`=1, `cascadeCfg`=0x00), automatic end of interrupt is off, and the block is operational.
- R2: A command-port write with bit 4 set starts initialization. In that first byte, bit 0=1 requests the mode byte, bit 1=1 selects single mode and bit 3=1 selects level inputs. The same write clears pending requests, the in-service set, the cascade byte and automatic end of interrupt. The data-port writes that follow are taken in this order: vector base; cascade byte (skipped when single); mode byte (skipped when bit 0 was 0). The block is then operational again. The mask is unchanged, and `intReq` stays low until the sequence is complete.
- R3: The vector equals the vector base with bits 2:0 replaced by the index of the winning input.
- R4: `cascadeCfg` shows the cascade byte from the last initialization, and `singleMode` shows bit 1 of the first byte.
- R5: A data-port write while operational replaces the mask. A data-port read returns the mask. A mask bit of 1 blocks that input.
- R6: `intReq` is high exactly when the block is operational and the lowest-index unmasked request is lower in index than every in-service bit.
- R7: An `intAck` pulse while `intReq` is high moves the winner into the in-service set, shown by a command-port read one bit per input. It also makes `vecValid` high for one cycle on the next cycle, carrying the vector. An `intAck` while `intReq` is low changes nothing.
- R8: A command-port write of 0x20 while operational clears the lowest-index in-service bit. Any other command byte with bit 4 clear has no effect.
- R9: In edge mode, a rising input is latched as pending and stays pending after the input falls. An input held high makes no second request.
- R10: In level mode, an input requests only while it is held high.
- R11: Bit 1 of the mode byte selects automatic end of interrupt. When it is set, an acknowledge delivers the vector but leaves the in-service set unchanged.
- R12: Within one cycle, a new rising edge on the input being acknowledged leaves that input pending again. An end-of-interrupt arriving with an acknowledge clears the old highest in-service bit and also records the new winner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | 0 selects the command port, 1 selects the data port |
| busWr | input | 1 | Write strobe for the selected port |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data: the mask on the data port, the in-service set on the command port |
| irqIn | input | 8 | Request lines, index 0 highest priority |
| intAck | input | 1 | One-cycle acknowledge from the processor |
| intReq | output | 1 | Interrupt request to the processor |
| vecOut | output | 8 | Vector for the acknowledged input |
| vecValid | output | 1 | High for one cycle when `vecOut` holds a new vector |
| cascadeCfg | output | 8 | Cascade byte from the last initialization |
| singleMode | output | 1 | High when no cascade is configured |

## Verification
Two pairs of events can collide in a single clock. An acknowledge can land in the same cycle as a fresh rising edge on the very line being acknowledged. A command-port end-of-interrupt write can land in the same cycle as an acknowledge. The bench creates both collisions on purpose. It first drops a latched line and raises it again on the acknowledge cycle, and later it drives the 0x20 write and `intAck` together while one level is already in service. A behavioural model, updated at each clock edge, predicts the pending set, the in-service set and the vector. The bench compares the request line, both read ports and the vector against that model on every cycle after the collisions.

// File: rtl/prio_intc_pkg.sv
package prio_intc_pkg;

  localparam int INIT_BIT   = 4;
  localparam int W1_MODE4   = 0;
  localparam int W1_SINGLE  = 1;
  localparam int W1_LEVEL   = 3;
  localparam int W4_AUTOEOI = 1;
  localparam logic [7:0] EOI_CMD = 8'h20;

  typedef enum logic [1:0] {
    ST_READY,
    ST_OFFSET,
    ST_CASC,
    ST_MODE
  } init_state_e;

  typedef struct packed {
    logic initStart;
    logic eoi;
    logic maskWr;
    logic offsetWr;
    logic cascWr;
    logic modeWr;
  } strobe_t;

endpackage

// File: rtl/prio_intc_ctrl.sv
module prio_intc_ctrl
  import prio_intc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [DATA_W-1:0] busWdata,
  output strobe_t           strb,
  output logic              ready,
  output logic              singleMode
);

  init_state_e state, stateNext;
  logic        needMode;

  assign ready = (state == ST_READY);

  always_comb begin
    strb = '0;
    if (busWr) begin
      if (!busSel) begin
        if (busWdata[INIT_BIT])
          strb.initStart = 1'b1;
        else if (ready && busWdata == DATA_W'(EOI_CMD))
          strb.eoi = 1'b1;
      end else begin
        unique case (state)
          ST_READY:  strb.maskWr   = 1'b1;
          ST_OFFSET: strb.offsetWr = 1'b1;
          ST_CASC:   strb.cascWr   = 1'b1;
          ST_MODE:   strb.modeWr   = 1'b1;
          default:   strb = '0;
        endcase
      end
    end
  end

  always_comb begin
    stateNext = state;
    if (strb.initStart)
      stateNext = ST_OFFSET;
    else if (strb.offsetWr)
      stateNext = !singleMode ? ST_CASC : (needMode ? ST_MODE : ST_READY);
    else if (strb.cascWr)
      stateNext = needMode ? ST_MODE : ST_READY;
    else if (strb.modeWr)
      stateNext = ST_READY;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_READY;
      singleMode <= 1'b1;
      needMode   <= 1'b0;
    end else begin
      state <= stateNext;
      if (strb.initStart) begin
        singleMode <= busWdata[W1_SINGLE];
        needMode   <= busWdata[W1_MODE4];
      end
    end
  end

  assert_casc_needs_cascade_R2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CASC) |-> !singleMode);

  assert_mode_needs_request_R2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_MODE) |-> needMode);

  assert_one_strobe_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb));

  assert_init_enters_offset_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.initStart |=> (state == ST_OFFSET));

endmodule

// File: rtl/prio_intc_dp.sv
module prio_intc_dp
  import prio_intc_pkg::*;
#(
  parameter int NUM_IRQ = 8,
  parameter int DATA_W  = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strb,
  input  logic               ready,
  input  logic [DATA_W-1:0]  busWdata,
  input  logic [NUM_IRQ-1:0] irqIn,
  input  logic               intAck,
  output logic               intReq,
  output logic [DATA_W-1:0]  vecOut,
  output logic               vecValid,
  output logic [NUM_IRQ-1:0] maskOut,
  output logic [NUM_IRQ-1:0] isrOut,
  output logic [DATA_W-1:0]  cascadeCfg
);

  localparam int IDX_W = $clog2(NUM_IRQ);
  localparam logic [IDX_W:0] NO_IDX = (IDX_W+1)'(NUM_IRQ);

  logic [NUM_IRQ-1:0] maskReg, pendReg, isrReg, irqPrev;
  logic [DATA_W-1:0]  offsetReg;
  logic               levelMode, autoEoi;

  logic [NUM_IRQ-1:0] reqVec, eligVec, edgeVec, winOneHot, svcOneHot, eoiClr, ackSet;
  logic [IDX_W:0]     winIdx, svcIdx;
  logic               ackHit;

  function automatic logic [IDX_W:0] lowestSet(input logic [NUM_IRQ-1:0] v);
    logic [IDX_W:0] r;
    r = NO_IDX;
    for (int i = NUM_IRQ - 1; i >= 0; i--)
      if (v[i]) r = (IDX_W+1)'(i);
    return r;
  endfunction

  assign edgeVec = irqIn & ~irqPrev;
  assign reqVec  = levelMode ? irqIn : pendReg;
  assign eligVec = reqVec & ~maskReg;
  assign winIdx  = lowestSet(eligVec);
  assign svcIdx  = lowestSet(isrReg);
  assign intReq  = ready && (winIdx < svcIdx);
  assign ackHit  = intAck && intReq;

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_onehot
    assign winOneHot[g] = (winIdx == (IDX_W+1)'(g));
    assign svcOneHot[g] = (svcIdx == (IDX_W+1)'(g));
  end

  assign eoiClr = strb.eoi ? svcOneHot : '0;
  assign ackSet = (ackHit && !autoEoi) ? winOneHot : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskReg   <= '1;
      pendReg   <= '0;
      isrReg    <= '0;
      irqPrev   <= '0;
      offsetReg <= '0;
      levelMode <= 1'b0;
      autoEoi   <= 1'b0;
      cascadeCfg <= '0;
      vecOut    <= '0;
      vecValid  <= 1'b0;
    end else begin
      irqPrev  <= irqIn;
      vecValid <= ackHit;
      if (ackHit)
        vecOut <= {offsetReg[DATA_W-1:IDX_W], winIdx[IDX_W-1:0]};

      if (strb.initStart) begin
        pendReg    <= '0;
        isrReg     <= '0;
        levelMode  <= busWdata[W1_LEVEL];
        autoEoi    <= 1'b0;
        cascadeCfg <= '0;
      end else begin
        pendReg <= (pendReg & ~(ackHit ? winOneHot : '0)) | edgeVec;
        isrReg  <= (isrReg & ~eoiClr) | ackSet;
      end

      if (strb.maskWr)   maskReg    <= busWdata[NUM_IRQ-1:0];
      if (strb.offsetWr) offsetReg  <= busWdata;
      if (strb.cascWr)   cascadeCfg <= busWdata;
      if (strb.modeWr)   autoEoi    <= busWdata[W4_AUTOEOI];
    end
  end

  assign maskOut = maskReg;
  assign isrOut  = isrReg;

  assert_vec_after_ack_R7: assert property (@(posedge clk) disable iff (!rstN)
    vecValid |-> $past(intAck));

  assert_vec_base_R3: assert property (@(posedge clk) disable iff (!rstN)
    vecValid |-> (vecOut[DATA_W-1:IDX_W] == offsetReg[DATA_W-1:IDX_W]));

  assert_isr_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.eoi && !strb.initStart && !intAck) |=> $stable(isrReg));

  assert_eoi_drops_one_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.eoi && !intAck && isrReg != '0) |=>
      ($countones(isrReg) == $countones($past(isrReg)) - 1));

  assert_auto_eoi_R11: assert property (@(posedge clk) disable iff (!rstN)
    (autoEoi && intAck && !strb.eoi && !strb.initStart) |=> $stable(isrReg));

  assert_level_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    (levelMode && (irqIn & ~maskReg) == '0) |-> !intReq);

endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import prio_intc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [DATA_W-1:0] irqIn,
  input  logic              intAck,
  output logic              intReq,
  output logic [DATA_W-1:0] vecOut,
  output logic              vecValid,
  output logic [DATA_W-1:0] cascadeCfg,
  output logic              singleMode
);

  localparam int NUM_IRQ = DATA_W;

  strobe_t            strb;
  logic               ready;
  logic [NUM_IRQ-1:0] maskOut, isrOut;

  prio_intc_ctrl #(.DATA_W(DATA_W)) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .busSel     (busSel),
    .busWr      (busWr),
    .busWdata   (busWdata),
    .strb       (strb),
    .ready      (ready),
    .singleMode (singleMode)
  );

  prio_intc_dp #(.NUM_IRQ(NUM_IRQ), .DATA_W(DATA_W)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .ready      (ready),
    .busWdata   (busWdata),
    .irqIn      (irqIn),
    .intAck     (intAck),
    .intReq     (intReq),
    .vecOut     (vecOut),
    .vecValid   (vecValid),
    .maskOut    (maskOut),
    .isrOut     (isrOut),
    .cascadeCfg (cascadeCfg)
  );

  assign busRdata = busSel ? maskOut : isrOut;

endmodule

// File: tb/prio_intc_tb_top.sv
`timescale 1ns/1ps
module prio_intc_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busSel = 1'b1;
  logic       busWr = 1'b0;
  logic [7:0] busWdata = 8'h00;
  logic [7:0] busRdata;
  logic [7:0] irqIn = 8'h00;
  logic       intAck = 1'b0;
  logic       intReq;
  logic [7:0] vecOut;
  logic       vecValid;
  logic [7:0] cascadeCfg;
  logic       singleMode;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;
  bit done    = 0;
  string phase = "R1 reset";

  always #2.5 clk = ~clk;

  prio_intc dut_i (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busWdata(busWdata),
    .busRdata(busRdata), .irqIn(irqIn), .intAck(intAck), .intReq(intReq),
    .vecOut(vecOut), .vecValid(vecValid), .cascadeCfg(cascadeCfg), .singleMode(singleMode)
  );

  // behavioural reference state
  int mMask = 255, mIsr = 0, mPend = 0, mPrev = 0, mOff = 0, mCasc = 0, mVec = 0;
  int mState = 0;  // 0 operational, 1 base, 2 cascade, 3 mode
  bit mLevel = 0, mAeoi = 0, mSingle = 1, mNeedW4 = 0, mVv = 0;

  function automatic int lowestOf(int v);
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return 8;
  endfunction

  function automatic bit modelReq();
    int req;
    req = mLevel ? int'(irqIn) : mPend;
    return (mState == 0) && (lowestOf(req & ~mMask & 255) < lowestOf(mIsr));
  endfunction

  always @(posedge clk) begin : model
    int req, w, h, edgeV, d;
    bit ackHit;
    if (!rstN) begin
      mMask = 255; mIsr = 0; mPend = 0; mPrev = 0; mOff = 0; mCasc = 0; mVec = 0;
      mState = 0; mLevel = 0; mAeoi = 0; mSingle = 1; mNeedW4 = 0; mVv = 0;
    end else begin
      d      = int'(busWdata);
      req    = mLevel ? int'(irqIn) : mPend;
      w      = lowestOf(req & ~mMask & 255);
      h      = lowestOf(mIsr);
      ackHit = intAck && modelReq();
      edgeV  = int'(irqIn) & ~mPrev & 255;
      mPrev  = int'(irqIn);
      mVv    = ackHit;
      if (ackHit) mVec = (mOff & 8'hF8) | w;
      if (busWr && !busSel && d[4]) begin
        mLevel = d[3]; mSingle = d[1]; mNeedW4 = d[0];
        mAeoi = 0; mCasc = 0; mState = 1; mIsr = 0; mPend = 0;
      end else begin
        if (ackHit) mPend = mPend & ~(1 << w);
        mPend = mPend | edgeV;
        if (busWr && !busSel && mState == 0 && d == 32 && h < 8) mIsr = mIsr & ~(1 << h);
        if (ackHit && !mAeoi) mIsr = mIsr | (1 << w);
        if (busWr && busSel) begin
          case (mState)
            0: mMask = d;
            1: begin mOff = d; mState = !mSingle ? 2 : (mNeedW4 ? 3 : 0); end
            2: begin mCasc = d; mState = mNeedW4 ? 3 : 0; end
            default: begin mAeoi = d[1]; mState = 0; end
          endcase
        end
      end
    end
  end

  task automatic cmp(string tag, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s [%s] actual=0x%0h expected=0x%0h at %0t", tag, phase, act, exp, $time);
    end
  endtask

  // compare against the model on every cycle, away from the active edge
  always @(negedge clk) begin
    #1;
    if (rstN && !done) begin
      cmp("R6 intReq", int'(intReq), int'(modelReq()));
      if (busSel) cmp("R5 mask read", int'(busRdata), mMask);
      else        cmp("R7 in-service read", int'(busRdata), mIsr);
      cmp("R7 vecValid", int'(vecValid), int'(mVv));
      if (mVv) cmp("R3 vector", int'(vecOut), mVec);
      cmp("R4 cascade byte", int'(cascadeCfg), mCasc);
      cmp("R4 single flag", int'(singleMode), int'(mSingle));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      nFails++;
      $display("FAIL watchdog expired actual=%0d expected<20000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      busSel = ~busSel;
    end
  endtask

  task automatic wr(bit sel, logic [7:0] d);
    @(negedge clk);
    busSel = sel; busWr = 1'b1; busWdata = d;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic ack();
    @(negedge clk);
    intAck = 1'b1;
    @(negedge clk);
    intAck = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    // R1: hand-computed reset values
    busSel = 1'b1; #0.1;
    cmp("R1 reset mask", int'(busRdata), 8'hFF);
    busSel = 1'b0; #0.1;
    cmp("R1 reset in-service", int'(busRdata), 0);
    cmp("R1 reset intReq", int'(intReq), 0);
    cmp("R1 reset single", int'(singleMode), 1);

    phase = "R5 mask write";
    wr(1, 8'h00);
    idle(2);

    phase = "R9 edge latch and nesting";
    @(negedge clk); irqIn = 8'h08;
    idle(2);
    @(negedge clk); irqIn = 8'h00;   // pending persists after fall
    idle(2);
    ack();
    idle(2);
    @(negedge clk); irqIn = 8'h02;   // higher priority nests
    idle(3);                         // held high: no second request
    ack();
    idle(2);
    @(negedge clk); irqIn = 8'h00;

    phase = "R8 ignored command and EOI";
    wr(0, 8'h0A);
    idle(1);
    wr(0, 8'h20);
    idle(1);
    wr(0, 8'h20);
    idle(2);

    phase = "R2 init restart clears state";
    @(negedge clk); irqIn = 8'h10;
    idle(1);
    ack();
    @(negedge clk); irqIn = 8'h00;
    wr(0, 8'h11);
    @(negedge clk); irqIn = 8'h01;   // edge during init: gated until done
    wr(1, 8'h40);
    wr(1, 8'h04);
    wr(1, 8'h03);
    idle(3);
    @(negedge clk); irqIn = 8'h00;

    phase = "R11 automatic end of interrupt";
    @(negedge clk); irqIn = 8'h20;
    idle(1);
    ack();
    idle(2);
    @(negedge clk); irqIn = 8'h00;

    phase = "R6 masked input";
    wr(1, 8'h04);
    @(negedge clk); irqIn = 8'h04;
    @(negedge clk); irqIn = 8'h00;
    idle(3);
    wr(1, 8'h00);
    idle(2);
    ack();
    idle(2);

    phase = "R2 cascaded without mode byte";
    wr(0, 8'h10);
    wr(1, 8'h08);
    wr(1, 8'h02);
    wr(1, 8'h00);
    idle(2);

    phase = "R10 level mode";
    wr(0, 8'h1B);
    wr(1, 8'h20);
    wr(1, 8'h01);
    @(negedge clk); irqIn = 8'h40;
    idle(2);
    @(negedge clk); irqIn = 8'h00;
    idle(1);
    ack();                           // R7: no request, no effect
    idle(1);
    @(negedge clk); irqIn = 8'h40;
    ack();
    idle(2);
    @(negedge clk); irqIn = 8'h00;
    wr(0, 8'h20);
    idle(2);

    phase = "R12 ack with fresh edge";
    wr(0, 8'h13);
    wr(1, 8'h80);
    wr(1, 8'h01);
    @(negedge clk); irqIn = 8'h10;
    @(negedge clk); irqIn = 8'h00;
    idle(1);
    @(negedge clk); irqIn = 8'h10; intAck = 1'b1;
    @(negedge clk); intAck = 1'b0;
    idle(3);
    @(negedge clk); irqIn = 8'h02;
    idle(2);

    phase = "R12 EOI with ack";
    @(negedge clk); busSel = 1'b0; busWr = 1'b1; busWdata = 8'h20; intAck = 1'b1;
    @(negedge clk); busWr = 1'b0; intAck = 1'b0;
    idle(3);
    @(negedge clk); irqIn = 8'h00;
    wr(0, 8'h20);
    idle(2);
    ack();
    idle(2);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule